// File: doc/BRIEF.md
# Group fault and OK-line manager

This block supervises up to four power groups, each tied together by one shared open-drain OK line with a pull-up. It senses each line and records a sticky fault when a member of the group pulls the line low. It can also pull a line low itself, either because a group is ordered off or because an interrupt asks for a short pause. The block tells its own pulling apart from a real fault, so it never reports its own action as a fault.

Four active-low interrupt inputs each have their own mode bit and target-group mask. In pause mode, asserting an interrupt pulls the target OK lines low for a fixed number of cycles and then lets them go, even while the interrupt stays asserted. In hot-swap mode, asserting it emits a one-cycle programming-start pulse for each target group. Releasing it marks those groups as disconnected. A sticky group fault can be routed through a per-group mask to turn off selected auxiliary-device enables. The OK lines and the interrupt pins each pass through a two-flop synchronizer and a glitch filter before the block acts on them.

Top module: `grp_ok_mgr`

## Requirements
- R1: A change on an OK line or interrupt pin is acted on only after it has held for FILT (default 4) consecutive synchronized cycles. A low pulse of 2 cycles on an OK line sets no fault, and one on an interrupt pulls no line.
- R2: When an OK line is held low from outside while the block is not pulling it, the sticky fault bit flt_sticky[g] of that group is set.
- R3: A sticky fault bit stays set until a one is written to flt_clr[g]. If the fault is still present in the same cycle as the clear, the bit stays set.
- R4: grp_off[g]=1 drives ok_pull[g]=1, where ok_pull=1 means the block pulls OK line g low.
- R5: A low level on a line the block is pulling sets no fault. This also holds for FILT+4 cycles after the block releases the line.
- R6: In pause mode (cfg_int_hs[i]=0), asserting int_n[i] pulls every target group low for PAUSE_CYC (default 16) cycles. Group g is a target when cfg_int_tgt[i*NGRP+g]=1. The pull then ends even if the interrupt is still low, and groups that are not targets are left alone.
- R7: In hot-swap mode (cfg_int_hs[i]=1), asserting int_n[i] gives exactly one one-cycle pulse on hs_prog[g] for each target group and does not pull any OK line.
- R8: Releasing a hot-swap interrupt sets hs_disc[g] for each target group. The bit is cleared when the next programming pulse for that group occurs, and hs_prog and hs_disc are never both high for one group.
- R9: aux_en[a] equals aux_en_req[a] except while some group g with flt_sticky[g]=1 has cfg_aux_map[g*NAUX+a]=1; in that case aux_en[a] is 0.
- R10: After reset, ok_pull, flt_sticky, hs_prog and hs_disc are all zero. The filters start at an idle level, which is lines high and interrupts released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ok_in | input | NGRP | Sensed level of each OK line |
| ok_pull | output | NGRP | 1 = block pulls the OK line low |
| int_n | input | NINT | Active-low interrupt pins |
| cfg_int_hs | input | NINT | Per interrupt: 1 = hot-swap, 0 = pause |
| cfg_int_tgt | input | NINT*NGRP | Target group mask, bit i*NGRP+g |
| grp_off | input | NGRP | Order to disable a group |
| flt_clr | input | NGRP | Write-one-to-clear of sticky faults |
| flt_sticky | output | NGRP | Sticky per-group fault status |
| cfg_aux_map | input | NGRP*NAUX | Fault routing, bit g*NAUX+a |
| aux_en_req | input | NAUX | Requested auxiliary enables |
| aux_en | output | NAUX | Auxiliary enables after fault gating |
| hs_prog | output | NGRP | One-cycle programming-start pulse |
| hs_disc | output | NGRP | Group converters marked disconnected |

## Verification
Suppose a filter counter or sync stage is wrong. Then a short glitch shows up as a fault bit or a line pull about six cycles later, or a real long fault never sets its bit. Suppose the holdoff mask is too short. Then flt_sticky sets within a few cycles of the block releasing a line it had pulled, or at the end of a pause. A wrong pause counter shows as ok_pull ending too early, or never ending, while the interrupt is held. A wrong hot-swap edge detector shows as a missing or repeated hs_prog pulse, or a hs_disc bit that never sets or never clears.

// File: rtl/grp_ok_mgr.sv
module grp_ok_mgr #(
  parameter int NGRP      = 4,
  parameter int NINT      = 4,
  parameter int NAUX      = 4,
  parameter int FILT      = 4,
  parameter int PAUSE_CYC = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NGRP-1:0]      ok_in,
  output logic [NGRP-1:0]      ok_pull,
  input  logic [NINT-1:0]      int_n,
  input  logic [NINT-1:0]      cfg_int_hs,
  input  logic [NINT*NGRP-1:0] cfg_int_tgt,
  input  logic [NGRP-1:0]      grp_off,
  input  logic [NGRP-1:0]      flt_clr,
  output logic [NGRP-1:0]      flt_sticky,
  input  logic [NGRP*NAUX-1:0] cfg_aux_map,
  input  logic [NAUX-1:0]      aux_en_req,
  output logic [NAUX-1:0]      aux_en,
  output logic [NGRP-1:0]      hs_prog,
  output logic [NGRP-1:0]      hs_disc
);
  localparam int NIN  = NGRP + NINT;
  localparam int FW   = $clog2(FILT + 1);
  localparam int PW   = $clog2(PAUSE_CYC + 1);
  localparam int HOLD = FILT + 4;
  localparam int HW   = $clog2(HOLD + 1);
  localparam logic [NIN-1:0] IDLE = {{NINT{1'b0}}, {NGRP{1'b1}}};

  logic [NIN-1:0]  raw, s1, s2, flt;
  logic [NGRP-1:0] ok_f, mask, flt_now, pause_grp, prog_c, rel_c;
  logic [NINT-1:0] ia, ia_q, ia_rise, ia_fall, pact;
  logic [NAUX-1:0] aux_blk;

  // synchronizer and glitch filter (R1)
  assign raw = {~int_n, ok_in};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= IDLE;
      s2 <= IDLE;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  for (genvar n = 0; n < NIN; n++) begin : g_filt
    logic [FW-1:0] cnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        cnt    <= '0;
        flt[n] <= IDLE[n];
      end else if (s2[n] == flt[n]) begin
        cnt <= '0;
      end else if (cnt == FW'(FILT - 1)) begin
        cnt    <= '0;
        flt[n] <= s2[n];
      end else begin
        cnt <= cnt + 1'b1;
      end
  end

  assign ok_f = flt[NGRP-1:0];
  assign ia   = flt[NIN-1:NGRP];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ia_q <= '0;
    else        ia_q <= ia;

  assign ia_rise = ia & ~ia_q;
  assign ia_fall = ~ia & ia_q;

  // pause timers, one per interrupt (R6)
  for (genvar i = 0; i < NINT; i++) begin : g_pause
    logic [PW-1:0] pcnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                           pcnt <= '0;
      else if (ia_rise[i] && !cfg_int_hs[i]) pcnt <= PW'(PAUSE_CYC);
      else if (pcnt != '0)                  pcnt <= pcnt - 1'b1;
    assign pact[i] = (pcnt != '0);
  end

  always_comb begin
    pause_grp = '0;
    prog_c    = '0;
    rel_c     = '0;
    for (int i = 0; i < NINT; i++)
      for (int g = 0; g < NGRP; g++)
        if (cfg_int_tgt[i*NGRP+g]) begin
          if (pact[i])                    pause_grp[g] = 1'b1;
          if (ia_rise[i] && cfg_int_hs[i]) prog_c[g]    = 1'b1;
          if (ia_fall[i] && cfg_int_hs[i]) rel_c[g]     = 1'b1;
        end
  end

  assign ok_pull = grp_off | pause_grp;

  // self-masking with holdoff after release (R5)
  for (genvar g = 0; g < NGRP; g++) begin : g_hold
    logic [HW-1:0] hcnt;
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)           hcnt <= '0;
      else if (ok_pull[g])  hcnt <= HW'(HOLD);
      else if (hcnt != '0)  hcnt <= hcnt - 1'b1;
    assign mask[g] = ok_pull[g] | (hcnt != '0);
  end

  assign flt_now = ~ok_f & ~mask;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt_sticky <= '0;
      hs_prog    <= '0;
      hs_disc    <= '0;
    end else begin
      flt_sticky <= (flt_sticky & ~flt_clr) | flt_now;
      hs_prog    <= prog_c;
      hs_disc    <= (hs_disc | rel_c) & ~prog_c;
    end

  // fault routing to auxiliary enables (R9)
  always_comb begin
    aux_blk = '0;
    for (int g = 0; g < NGRP; g++)
      for (int a = 0; a < NAUX; a++)
        if (flt_sticky[g] && cfg_aux_map[g*NAUX+a]) aux_blk[a] = 1'b1;
  end

  assign aux_en = aux_en_req & ~aux_blk;

  p_sticky_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(flt_sticky) & ~$past(flt_clr)) & ~flt_sticky) == '0));

  p_no_self_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((flt_sticky & ~$past(flt_sticky)) & $past(ok_pull)) == '0));

  p_prog_disc_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_prog & hs_disc) == '0);

  p_aux_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_en & ~aux_en_req) == '0);

  p_off_pulls_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_off & ~ok_pull) == '0);
endmodule

// File: tb/test_grp_ok_mgr.sv
module test_grp_ok_mgr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ok_in, ok_pull, int_n, cfg_int_hs, grp_off, flt_clr, flt_sticky;
  logic [15:0] cfg_int_tgt, cfg_aux_map;
  logic [3:0]  aux_en_req, aux_en, hs_prog, hs_disc;
  logic [3:0]  ext_low;
  int total = 0;
  int bad = 0;
  int pc [4];

  always #5 clk = ~clk;

  assign ok_in = ~(ok_pull | ext_low);

  grp_ok_mgr i_grp_ok_mgr (
    .clk(clk), .rst_n(rst_n), .ok_in(ok_in), .ok_pull(ok_pull), .int_n(int_n),
    .cfg_int_hs(cfg_int_hs), .cfg_int_tgt(cfg_int_tgt), .grp_off(grp_off),
    .flt_clr(flt_clr), .flt_sticky(flt_sticky), .cfg_aux_map(cfg_aux_map),
    .aux_en_req(aux_en_req), .aux_en(aux_en), .hs_prog(hs_prog), .hs_disc(hs_disc));

  always @(posedge clk)
    if (rst_n)
      for (int g = 0; g < 4; g++) if (hs_prog[g]) pc[g]++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    cyc(2);
    chk("R10 ok_pull", ok_pull, 0);
    chk("R10 sticky", flt_sticky, 0);
    chk("R10 hs_prog", hs_prog, 0);
    chk("R10 hs_disc", hs_disc, 0);
    rst_n = 1'b1;
    cyc(12);
    chk("R10 idle sticky", flt_sticky, 0);
    chk("R10 idle pull", ok_pull, 0);
  endtask

  task automatic t_fault;
    ext_low[1] = 1'b1;
    cyc(12);
    chk("R2 fault set", flt_sticky, 4'b0010);
    chk("R9 aux off", aux_en, 4'b1011);
    ext_low[1] = 1'b0;
    cyc(12);
    chk("R3 sticky holds", flt_sticky, 4'b0010);
    flt_clr[1] = 1'b1; cyc(1); flt_clr[1] = 1'b0;
    cyc(2);
    chk("R3 cleared", flt_sticky, 0);
    chk("R9 aux back", aux_en, 4'b1111);
  endtask

  task automatic t_set_wins;
    ext_low[3] = 1'b1;
    cyc(12);
    chk("R2 fault g3", flt_sticky, 4'b1000);
    flt_clr[3] = 1'b1; cyc(1); flt_clr[3] = 1'b0;
    cyc(2);
    chk("R3 set wins", flt_sticky, 4'b1000);
    ext_low[3] = 1'b0;
    cyc(12);
    flt_clr = 4'hF; cyc(1); flt_clr = 4'h0;
    cyc(2);
    chk("R3 clear after release", flt_sticky, 0);
  endtask

  task automatic t_glitch;
    logic seen;
    ext_low[0] = 1'b1; cyc(2); ext_low[0] = 1'b0;
    cyc(12);
    chk("R1 ok glitch", flt_sticky, 0);
    cfg_int_hs[0] = 1'b0;
    cfg_int_tgt[3:0] = 4'b0001;
    seen = 1'b0;
    int_n[0] = 1'b0; cyc(2); int_n[0] = 1'b1;
    for (int k = 0; k < 20; k++) begin
      cyc(1);
      if (ok_pull != 0) seen = 1'b1;
    end
    chk("R1 int glitch", {31'd0, seen}, 0);
    cfg_int_tgt[3:0] = 4'b0000;
  endtask

  task automatic t_off_mask;
    grp_off[2] = 1'b1;
    cyc(12);
    chk("R4 pull", ok_pull, 4'b0100);
    chk("R5 masked while pulled", flt_sticky, 0);
    grp_off[2] = 1'b0;
    cyc(20);
    chk("R5 masked after release", flt_sticky, 0);
    chk("R4 released", ok_pull, 0);
  endtask

  task automatic t_pause;
    cfg_int_hs[1] = 1'b0;
    cfg_int_tgt[7:4] = 4'b0101;
    int_n[1] = 1'b0;
    cyc(10);
    chk("R6 targets pulled", ok_pull, 4'b0101);
    cyc(25);
    chk("R6 pause ends while held", ok_pull, 0);
    chk("R5 no fault from pause", flt_sticky, 0);
    int_n[1] = 1'b1;
    cyc(12);
    chk("R6 no pull on release", ok_pull, 0);
    cfg_int_tgt[7:4] = 4'b0000;
  endtask

  task automatic t_hotswap;
    cfg_int_hs[2] = 1'b1;
    cfg_int_tgt[11:8] = 4'b1010;
    for (int g = 0; g < 4; g++) pc[g] = 0;
    int_n[2] = 1'b0;
    cyc(15);
    chk("R7 prog g1", pc[1], 1);
    chk("R7 prog g3", pc[3], 1);
    chk("R7 no prog g0", pc[0], 0);
    chk("R7 no pull", ok_pull, 0);
    chk("R8 not disc", hs_disc, 0);
    int_n[2] = 1'b1;
    cyc(15);
    chk("R8 disc set", hs_disc, 4'b1010);
    chk("R7 no prog on release", pc[1], 1);
    int_n[2] = 1'b0;
    cyc(15);
    chk("R8 disc cleared", hs_disc, 0);
    chk("R7 second prog", pc[3], 2);
    int_n[2] = 1'b1;
    cyc(15);
  endtask

  initial begin
    ext_low = 0; int_n = 4'hF; cfg_int_hs = 0; cfg_int_tgt = 0; grp_off = 0;
    flt_clr = 0; aux_en_req = 4'hF; cfg_aux_map = 16'h0;
    cfg_aux_map[1*4+2] = 1'b1;
    t_reset;
    t_fault;
    t_set_wins;
    t_glitch;
    t_off_mask;
    t_pause;
    t_hotswap;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule